// File: doc/BRIEF.md
# Video Memory Bus Address Controller

This block drives the address side of the external memory bus of a tile-based video processor. It keeps two address registers. The first is a 15-bit video address that the CPU programs and steps through a data port. The second is a 14-bit bus address that is actually presented to memory and to the cartridge-side logic that watches address changes. Whenever the bus address register is loaded, a one-cycle change strobe tells those watchers that the bus has moved.

Outside active rendering, every CPU-side change to the video address is copied onto the bus. During rendering, the fetch schedule owns the bus. On each scanline it issues nametable and attribute fetches, including the dummy fetches inside the sprite window and the two trailing nametable fetches. CPU data-port accesses always use whatever address the bus holds at that moment. A data-port read returns a buffered byte and then refills that buffer from the bus. Reads in the palette range return palette data instead. The block also flags the shortened pre-render line used on odd frames in 60 Hz timing.

Top module: `vbus_addr_ctrl`

## Requirements
- R1: While `rst` is high and after it is released, `bus_addr`, `mem_addr` and `cpu_rdata` are 0, and `bus_chg`, `mem_rd`, `mem_wr` and `skip_dot` are low until the first access or fetch.
- R2: The address port (`cpu_sel`=1) takes two writes. The first write supplies address bits 13:8 from data bits 5:0 and clears bit 14. The second write supplies bits 7:0. The full value is loaded into the video address LOAD_DELAY clock edges after the edge that samples the second write.
- R3: "Rendering" means `render_en` is high and `scanline` is either below 240 or equal to 261. A CPU-side change to the video address (delayed load or increment) is copied to `bus_addr` (bits 13:0) only when the block is not rendering. During rendering only fetches move `bus_addr`.
- R4: Every data-port access (`cpu_sel`=2) advances the video address one edge later. The step is 32 when the last control-port write (`cpu_sel`=0) had data bit 2 set, and 1 otherwise. The sum wraps within 15 bits.
- R5: A data-port write raises `mem_wr` for one cycle with `mem_wdata` and with `mem_addr` equal to the bus address held before the access.
- R6: A data-port read raises `mem_rd` at the current bus address and returns the previously buffered byte. The buffer is refilled from `mem_rdata` at the end of that read cycle. When video address bits 13:0 are at least 0x3F00, the read returns `pal_rdata` instead, where `pal_idx` is video address bits 4:0.
- R7: `bus_chg` is high for exactly one cycle after each load of `bus_addr`. A fetch loads `bus_addr` and raises `mem_rd` with `mem_addr` equal to that address.
- R8: While rendering, a nametable fetch at address 0x2000|v[11:0] is issued at dots with (dot mod 8)=1 up to dot 329, and at dots 337 and 339. An attribute fetch at 0x23C0|v[11:10]<<10|v[9:7]<<3|v[4:2] is issued at dots with (dot mod 8)=3 up to dot 331.
- R9: `skip_dot` pulses one cycle after dot 339 of scanline 261 when `render_en`, `odd_frame` and `short_mode` are all high.
- R10: Addresses 0x3000 to 0x3FFF are placed on the bus unchanged; they are not folded down to 0x2000 to 0x2FFF.
- R11: When a fetch and a data-port access fall on the same edge, the fetch takes the memory port. The data-port memory operation is dropped, but the address increment still happens.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_sel | input | 2 | Register select: 0 control, 1 address, 2 data, 3 none |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Data-port read result |
| scanline | input | 9 | Current scanline from the timing generator |
| dot | input | 9 | Current dot within the scanline |
| render_en | input | 1 | Background or sprite rendering enabled |
| odd_frame | input | 1 | Current frame is odd |
| short_mode | input | 1 | 60 Hz timing mode |
| skip_dot | output | 1 | The line ends one dot early |
| bus_addr | output | 14 | Bus address seen by address watchers |
| bus_chg | output | 1 | Bus address was just loaded |
| mem_addr | output | 14 | Address of the current memory operation |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid while mem_rd is high |
| pal_idx | output | 5 | Palette entry addressed by the video address |
| pal_rdata | input | 8 | Palette data for pal_idx |

## Verification
Some properties are checked on every cycle. These cover: the bus never moving without the change strobe; the bus moving during rendering only through a fetch; every fetch being a read at the bus address; writes going to the address the bus held beforehand; and reads and writes never overlapping. Other behaviour only shows up in the bench's directed scenarios, run against its behavioural model. That includes the delayed load, the step sizes and 15-bit wrap, the buffered and palette reads, the exact dots of the fetch schedule with its formula-derived addresses, the shortened pre-render line, and a data access colliding with a fetch.

// File: rtl/vbus_pkg.sv
package vbus_pkg;
  localparam int unsigned VADDR_W = 15;
  localparam int unsigned BADDR_W = 14;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned PAL_W   = 5;
  localparam logic [BADDR_W-1:0] PAL_BASE = 14'h3F00;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_DATA = 2'd2,
    SEL_NONE = 2'd3
  } cpu_sel_e;

  typedef enum logic [1:0] {
    FK_NONE = 2'd0,
    FK_NT   = 2'd1,
    FK_AT   = 2'd2
  } fetch_kind_e;

  function automatic logic [BADDR_W-1:0] nt_fetch_addr(input logic [VADDR_W-1:0] v);
    return 14'h2000 | {2'b00, v[11:0]};
  endfunction

  function automatic logic [BADDR_W-1:0] at_fetch_addr(input logic [VADDR_W-1:0] v);
    return 14'h23C0 | {2'b00, v[11:10], 10'b0} | {8'b0, v[9:7], 3'b0} | {11'b0, v[4:2]};
  endfunction
endpackage

// File: rtl/vbus_addr_reg.sv
module vbus_addr_reg
  import vbus_pkg::*;
#(
  parameter int LOAD_DELAY = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cpu_wr,
  input  cpu_sel_e           sel,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               inc_now,
  output logic [VADDR_W-1:0] vaddr,
  output logic               upd_valid,
  output logic [VADDR_W-1:0] upd_addr
);
  localparam int DLY_W = $clog2(LOAD_DELAY + 1);
  localparam int HI_W  = BADDR_W - DATA_W;

  logic [HI_W-1:0]    hi_q;
  logic               second_q;
  logic [VADDR_W-1:0] pend_q;
  logic [DLY_W-1:0]   dly_q;
  logic               vstep_q;
  logic               load_done;
  logic [VADDR_W-1:0] step;
  logic               addr_wr;

  assign addr_wr   = cpu_wr && (sel == SEL_ADDR);
  assign load_done = (dly_q == DLY_W'(1));
  assign step      = vstep_q ? VADDR_W'(32) : VADDR_W'(1);
  assign upd_valid = load_done | inc_now;
  assign upd_addr  = load_done ? pend_q : (vaddr + step);

  always_ff @(posedge clk) begin
    if (rst) begin
      vaddr    <= '0;
      hi_q     <= '0;
      second_q <= 1'b0;
      pend_q   <= '0;
      dly_q    <= '0;
      vstep_q  <= 1'b0;
    end else begin
      if (upd_valid) vaddr <= upd_addr;
      if (addr_wr && second_q) begin
        pend_q <= {1'b0, hi_q, wdata};
        dly_q  <= DLY_W'(LOAD_DELAY);
      end else if (dly_q != '0) begin
        dly_q <= dly_q - DLY_W'(1);
      end
      if (addr_wr) begin
        second_q <= ~second_q;
        if (!second_q) hi_q <= wdata[HI_W-1:0];
      end
      if (cpu_wr && (sel == SEL_CTRL)) vstep_q <= wdata[2];
    end
  end
endmodule

// File: rtl/vbus_fetch_sched.sv
module vbus_fetch_sched
  import vbus_pkg::*;
#(
  parameter int LINE_W    = 9,
  parameter int DOT_W     = 9,
  parameter int VIS_LINES = 240,
  parameter int PRE_LINE  = 261,
  parameter int NT_LAST   = 329,
  parameter int AT_LAST   = 331,
  parameter int TAIL_NT_A = 337,
  parameter int TAIL_NT_B = 339
) (
  input  logic [LINE_W-1:0] scanline,
  input  logic [DOT_W-1:0]  dot,
  input  logic              render_en,
  input  logic              odd_frame,
  input  logic              short_mode,
  output logic              active,
  output fetch_kind_e       kind,
  output logic              skip_req
);
  localparam int N_TAIL = 2;
  localparam logic [DOT_W-1:0] TAIL_DOTS [N_TAIL] = '{DOT_W'(TAIL_NT_A), DOT_W'(TAIL_NT_B)};

  logic [2:0]        phase;
  logic [N_TAIL-1:0] tail_hit;
  logic              nt_hit;
  logic              at_hit;
  logic              pre_line;

  assign phase    = dot[2:0];
  assign pre_line = (scanline == LINE_W'(PRE_LINE));
  assign active   = render_en && ((scanline < LINE_W'(VIS_LINES)) || pre_line);

  for (genvar i = 0; i < N_TAIL; i++) begin : g_tail
    assign tail_hit[i] = (dot == TAIL_DOTS[i]);
  end

  assign nt_hit = ((phase == 3'd1) && (dot <= DOT_W'(NT_LAST))) || (|tail_hit);
  assign at_hit = (phase == 3'd3) && (dot <= DOT_W'(AT_LAST));

  always_comb begin
    kind = FK_NONE;
    if (active) begin
      if (nt_hit)      kind = FK_NT;
      else if (at_hit) kind = FK_AT;
    end
  end

  assign skip_req = render_en && pre_line && (dot == DOT_W'(TAIL_NT_B)) && odd_frame && short_mode;
endmodule

// File: rtl/vbus_bus_ctrl.sv
module vbus_bus_ctrl
  import vbus_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               active,
  input  fetch_kind_e        kind,
  input  logic [VADDR_W-1:0] vaddr,
  input  logic               upd_valid,
  input  logic [VADDR_W-1:0] upd_addr,
  input  logic               cpu_rd,
  input  logic               cpu_wr,
  input  cpu_sel_e           sel,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [DATA_W-1:0]  mem_rdata,
  input  logic [DATA_W-1:0]  pal_rdata,
  input  logic               skip_req,
  output logic [BADDR_W-1:0] bus_addr,
  output logic               bus_chg,
  output logic [BADDR_W-1:0] mem_addr,
  output logic               mem_rd,
  output logic               mem_wr,
  output logic [DATA_W-1:0]  mem_wdata,
  output logic [DATA_W-1:0]  cpu_rdata,
  output logic               skip_dot,
  output logic               inc_now
);
  logic               fetch;
  logic [BADDR_W-1:0] faddr;
  logic               data_rd;
  logic               data_wr;
  logic               cpu_op;
  logic               bus_load;
  logic [BADDR_W-1:0] bus_next;
  logic               refill_q;
  logic [DATA_W-1:0]  rbuf_q;
  logic               pal_zone;

  assign fetch    = (kind != FK_NONE);
  assign faddr    = (kind == FK_AT) ? at_fetch_addr(vaddr) : nt_fetch_addr(vaddr);
  assign data_wr  = cpu_wr && (sel == SEL_DATA);
  assign data_rd  = cpu_rd && !cpu_wr && (sel == SEL_DATA);
  assign cpu_op   = (data_rd || data_wr) && !fetch;
  assign bus_load = fetch || (upd_valid && !active);
  assign bus_next = fetch ? faddr : upd_addr[BADDR_W-1:0];
  assign pal_zone = (vaddr[BADDR_W-1:0] >= PAL_BASE);

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_addr  <= '0;
      bus_chg   <= 1'b0;
      mem_addr  <= '0;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      mem_wdata <= '0;
      cpu_rdata <= '0;
      skip_dot  <= 1'b0;
      inc_now   <= 1'b0;
      refill_q  <= 1'b0;
      rbuf_q    <= '0;
    end else begin
      bus_chg <= bus_load;
      if (bus_load) bus_addr <= bus_next;

      if (fetch)       mem_addr <= faddr;
      else if (cpu_op) mem_addr <= bus_addr;
      else if (bus_load) mem_addr <= bus_next;

      mem_rd <= fetch || data_rd;
      mem_wr <= data_wr && !fetch;
      if (data_wr) mem_wdata <= wdata;

      inc_now  <= data_rd || data_wr;
      refill_q <= data_rd && !fetch;
      if (refill_q) rbuf_q <= mem_rdata;
      if (data_rd) cpu_rdata <= pal_zone ? pal_rdata : rbuf_q;

      skip_dot <= skip_req;
    end
  end
endmodule

// File: rtl/vbus_addr_ctrl.sv
module vbus_addr_ctrl
  import vbus_pkg::*;
#(
  parameter int LOAD_DELAY = 3,
  parameter int LINE_W     = 9,
  parameter int DOT_W      = 9,
  parameter int VIS_LINES  = 240,
  parameter int PRE_LINE   = 261
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         cpu_sel,
  input  logic               cpu_rd,
  input  logic               cpu_wr,
  input  logic [DATA_W-1:0]  cpu_wdata,
  output logic [DATA_W-1:0]  cpu_rdata,
  input  logic [LINE_W-1:0]  scanline,
  input  logic [DOT_W-1:0]   dot,
  input  logic               render_en,
  input  logic               odd_frame,
  input  logic               short_mode,
  output logic               skip_dot,
  output logic [BADDR_W-1:0] bus_addr,
  output logic               bus_chg,
  output logic [BADDR_W-1:0] mem_addr,
  output logic               mem_rd,
  output logic               mem_wr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic [PAL_W-1:0]   pal_idx,
  input  logic [DATA_W-1:0]  pal_rdata
);
  cpu_sel_e           sel;
  logic [VADDR_W-1:0] vaddr;
  logic               upd_valid;
  logic [VADDR_W-1:0] upd_addr;
  logic               inc_now;
  logic               sched_active;
  fetch_kind_e        sched_kind;
  logic               skip_req;
  logic               fetch_any;

  assign sel       = cpu_sel_e'(cpu_sel);
  assign pal_idx   = vaddr[PAL_W-1:0];
  assign fetch_any = (sched_kind != FK_NONE);

  vbus_addr_reg #(.LOAD_DELAY(LOAD_DELAY)) u_areg (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .sel(sel), .wdata(cpu_wdata),
    .inc_now(inc_now), .vaddr(vaddr), .upd_valid(upd_valid), .upd_addr(upd_addr)
  );

  vbus_fetch_sched #(
    .LINE_W(LINE_W), .DOT_W(DOT_W), .VIS_LINES(VIS_LINES), .PRE_LINE(PRE_LINE)
  ) u_sched (
    .scanline(scanline), .dot(dot), .render_en(render_en), .odd_frame(odd_frame),
    .short_mode(short_mode), .active(sched_active), .kind(sched_kind), .skip_req(skip_req)
  );

  vbus_bus_ctrl u_bus (
    .clk(clk), .rst(rst), .active(sched_active), .kind(sched_kind), .vaddr(vaddr),
    .upd_valid(upd_valid), .upd_addr(upd_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .sel(sel), .wdata(cpu_wdata), .mem_rdata(mem_rdata), .pal_rdata(pal_rdata),
    .skip_req(skip_req), .bus_addr(bus_addr), .bus_chg(bus_chg), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata), .cpu_rdata(cpu_rdata),
    .skip_dot(skip_dot), .inc_now(inc_now)
  );
endmodule

// File: rtl/vbus_addr_ctrl_chk.sv
module vbus_addr_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic [13:0] bus_addr,
  input logic        bus_chg,
  input logic [13:0] mem_addr,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic        active,
  input logic        fetch_any
);
  AST_ONE_MEM_OP: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr)); // R11

  AST_CHG_ON_MOVE: assert property (@(posedge clk) disable iff (rst)
    (bus_addr != $past(bus_addr)) |-> bus_chg); // R7

  AST_RENDER_BUS_OWNED: assert property (@(posedge clk) disable iff (rst)
    (bus_chg && $past(active)) |-> $past(fetch_any)); // R3

  AST_FETCH_READS_BUS: assert property (@(posedge clk) disable iff (rst)
    $past(fetch_any) |-> (mem_rd && !mem_wr && (mem_addr == bus_addr))); // R8

  AST_WRITE_AT_OLD_BUS: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> (mem_addr == $past(bus_addr))); // R5
endmodule

bind vbus_addr_ctrl vbus_addr_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_chg(bus_chg), .mem_addr(mem_addr),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .active(sched_active), .fetch_any(fetch_any)
);

// File: tb/vbus_addr_ctrl_tb.sv
`timescale 1ns/1ps
module vbus_addr_ctrl_tb;
  localparam int LD = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cpu_sel = 2'd3;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [7:0]  cpu_wdata = 8'h00;
  logic [7:0]  cpu_rdata;
  logic [8:0]  scanline = 9'd250;
  logic [8:0]  dot = 9'd0;
  logic        render_en = 1'b0, odd_frame = 1'b0, short_mode = 1'b0;
  logic        skip_dot, bus_chg, mem_rd, mem_wr;
  logic [13:0] bus_addr, mem_addr;
  logic [7:0]  mem_wdata, mem_rdata, pal_rdata;
  logic [4:0]  pal_idx;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  function automatic int memf(input int a);
    return (a * 7 + 3) & 'hFF;
  endfunction

  assign mem_rdata = mem_rd ? 8'(memf(int'(mem_addr))) : 8'h00;
  assign pal_rdata = 8'hA0 | {3'b000, pal_idx};

  vbus_addr_ctrl u_dut (
    .clk(clk), .rst(rst), .cpu_sel(cpu_sel), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .scanline(scanline), .dot(dot),
    .render_en(render_en), .odd_frame(odd_frame), .short_mode(short_mode),
    .skip_dot(skip_dot), .bus_addr(bus_addr), .bus_chg(bus_chg), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .pal_idx(pal_idx), .pal_rdata(pal_rdata)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_v, m_hi, m_second, m_pend, m_dly, m_vstep, m_bus, m_chg, m_rd, m_wr;
  int m_maddr, m_wd, m_buf, m_cpu, m_skip, m_acc, m_refill;
  int t_act, t_f, t_fa, t_drd, t_dwr, t_upd, t_nv, t_nbuf, t_nbus, t_nchg, t_ndly;

  always @(posedge clk) begin
    if (rst) begin
      m_v = 0; m_hi = 0; m_second = 0; m_pend = 0; m_dly = 0; m_vstep = 0;
      m_bus = 0; m_chg = 0; m_rd = 0; m_wr = 0; m_maddr = 0; m_wd = 0;
      m_buf = 0; m_cpu = 0; m_skip = 0; m_acc = 0; m_refill = 0;
    end else begin
      t_act = (render_en && (scanline < 240 || scanline == 261)) ? 1 : 0;
      t_f = 0; t_fa = 0;
      if (t_act == 1) begin
        if ((dot % 8 == 1 && dot <= 329) || dot == 337 || dot == 339) begin
          t_f = 1; t_fa = 'h2000 | (m_v & 'hFFF);
        end else if (dot % 8 == 3 && dot <= 331) begin
          t_f = 1;
          t_fa = 'h23C0 | (m_v & 'h0C00) | ((m_v >> 4) & 'h38) | ((m_v >> 2) & 'h07);
        end
      end
      t_dwr = (cpu_wr && cpu_sel == 2) ? 1 : 0;
      t_drd = (cpu_rd && !cpu_wr && cpu_sel == 2) ? 1 : 0;
      t_nbuf = (m_refill == 1) ? memf(m_maddr) : m_buf;
      t_upd = (m_dly == 1 || m_acc == 1) ? 1 : 0;
      t_nv = (m_dly == 1) ? m_pend : ((m_v + ((m_vstep == 1) ? 32 : 1)) & 'h7FFF);
      if (t_f == 1) begin t_nbus = t_fa; t_nchg = 1; end
      else if (t_upd == 1 && t_act == 0) begin t_nbus = t_nv & 'h3FFF; t_nchg = 1; end
      else begin t_nbus = m_bus; t_nchg = 0; end
      if (t_f == 1) m_maddr = t_fa;
      else if (t_drd == 1 || t_dwr == 1) m_maddr = m_bus;
      else m_maddr = t_nbus;
      m_rd = (t_f == 1 || t_drd == 1) ? 1 : 0;
      m_wr = (t_dwr == 1 && t_f == 0) ? 1 : 0;
      if (t_dwr == 1) m_wd = cpu_wdata;
      if (t_drd == 1) m_cpu = ((m_v & 'h3FFF) >= 'h3F00) ? ('hA0 | (m_v & 31)) : m_buf;
      m_refill = (t_drd == 1 && t_f == 0) ? 1 : 0;
      m_acc = (t_drd == 1 || t_dwr == 1) ? 1 : 0;
      t_ndly = m_dly;
      if (cpu_wr && cpu_sel == 1 && m_second == 1) begin
        m_pend = (m_hi << 8) | cpu_wdata; t_ndly = LD;
      end else if (m_dly > 0) t_ndly = m_dly - 1;
      if (cpu_wr && cpu_sel == 1) begin
        if (m_second == 0) m_hi = cpu_wdata & 63;
        m_second = 1 - m_second;
      end
      if (cpu_wr && cpu_sel == 0) m_vstep = cpu_wdata[2];
      m_skip = (render_en && scanline == 261 && dot == 339 && odd_frame && short_mode) ? 1 : 0;
      if (t_upd == 1) m_v = t_nv;
      m_dly = t_ndly; m_buf = t_nbuf; m_bus = t_nbus; m_chg = t_nchg;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk("R3 bus_addr vs model", int'(bus_addr), m_bus);
      chk("R7 bus_chg vs model", int'(bus_chg), m_chg);
      chk("R8 mem_rd vs model", int'(mem_rd), m_rd);
      chk("R5 mem_wr vs model", int'(mem_wr), m_wr);
      chk("R7 mem_addr vs model", int'(mem_addr), m_maddr);
      if (mem_wr) chk("R5 mem_wdata vs model", int'(mem_wdata), m_wd);
      chk("R6 cpu_rdata vs model", int'(cpu_rdata), m_cpu);
      chk("R6 pal_idx vs model", int'(pal_idx), m_v & 31);
      chk("R9 skip_dot vs model", int'(skip_dot), m_skip);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cpu_w(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); cpu_sel = s; cpu_wr = 1'b1; cpu_wdata = d;
    @(negedge clk); cpu_wr = 1'b0; cpu_sel = 2'd3;
  endtask

  task automatic cpu_r();
    @(negedge clk); cpu_sel = 2'd2; cpu_rd = 1'b1;
    @(negedge clk); cpu_rd = 1'b0; cpu_sel = 2'd3;
  endtask

  task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo);
    cpu_w(2'd1, hi);
    cpu_w(2'd1, lo);
    idle(LD + 1);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog (R1..all): actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    // R1: reset state
    chk("R1 bus_addr at reset", int'(bus_addr), 0);
    chk("R1 bus_chg at reset", int'(bus_chg), 0);
    chk("R1 mem strobes at reset", int'({mem_rd, mem_wr}), 0);
    chk("R1 cpu_rdata at reset", int'(cpu_rdata), 0);
    chk("R1 skip_dot at reset", int'(skip_dot), 0);
    rst = 1'b0;
    idle(2);
    chk("R1 bus_addr after release", int'(bus_addr), 0);

    // R2: two-write load with delay
    cpu_w(2'd0, 8'h00);
    cpu_w(2'd1, 8'h21);
    cpu_w(2'd1, 8'h05);
    idle(LD - 1);
    chk("R2 bus not yet loaded", int'(bus_addr), 0);
    idle(2);
    chk("R2 bus after delayed load", int'(bus_addr), 'h2105);

    // R5 / R4: data write, step 1
    cpu_w(2'd2, 8'hAA);
    chk("R5 mem_wr on data write", int'(mem_wr), 1);
    chk("R5 write address", int'(mem_addr), 'h2105);
    chk("R5 write data", int'(mem_wdata), 'hAA);
    idle(2);
    chk("R4 step of one", int'(bus_addr), 'h2106);

    // R4: step of 32
    cpu_w(2'd0, 8'h04);
    cpu_w(2'd2, 8'h55);
    idle(2);
    chk("R4 step of 32", int'(bus_addr), 'h2126);

    // R6: buffered read
    cpu_w(2'd0, 8'h00);
    set_addr(8'h00, 8'h10);
    cpu_r();
    chk("R6 first read returns old buffer", int'(cpu_rdata), 0);
    chk("R6 read at bus address", int'(mem_addr), 'h0010);
    idle(1);
    cpu_r();
    chk("R6 second read returns refilled byte", int'(cpu_rdata), memf('h0010));

    // R6: palette range
    set_addr(8'h3F, 8'h05);
    cpu_r();
    chk("R6 palette read", int'(cpu_rdata), 'hA5);

    // R10: mirror range kept on the bus
    set_addr(8'h31, 8'h23);
    chk("R10 mirror address unchanged", int'(bus_addr), 'h3123);

    // R4: 15-bit wrap
    cpu_w(2'd0, 8'h04);
    set_addr(8'h3F, 8'hFF);
    for (int i = 0; i < 512; i++) cpu_w(2'd2, 8'h00);
    idle(1);
    chk("R4 top of 15-bit range", int'(bus_addr), 'h3FFF);
    cpu_w(2'd2, 8'h00);
    idle(2);
    chk("R4 wrap within 15 bits", int'(bus_addr), 'h001F);

    // R8: one rendered line
    cpu_w(2'd0, 8'h00);
    set_addr(8'h2A, 8'hBC);
    scanline = 9'd0; render_en = 1'b1;
    for (int c = 0; c < 341; c++) begin
      @(negedge clk);
      if (c == 258) chk("R8 dummy nametable fetch at 257", int'(bus_addr), 'h2ABC);
      if (c == 260) chk("R8 dummy attribute fetch at 259", int'(bus_addr), 'h2BEF);
      if (c == 260) chk("R7 fetch strobe", int'(bus_chg), 1);
      dot = 9'(c);
    end

    // R9: short pre-render line, even then odd frame
    for (int fr = 0; fr < 2; fr++) begin
      scanline = 9'd261; odd_frame = (fr == 1); short_mode = 1'b1;
      for (int c = 0; c < 341; c++) begin
        @(negedge clk);
        if (c == 340) chk("R9 skip_dot after dot 339", int'(skip_dot), fr);
        dot = 9'(c);
      end
    end
    odd_frame = 1'b0; short_mode = 1'b0;

    // R11: data write colliding with a fetch
    @(negedge clk); scanline = 9'd5; dot = 9'd1;
    cpu_w(2'd2, 8'h77);
    chk("R11 write dropped on collision", int'(mem_wr), 0);
    chk("R11 fetch keeps the port", int'(mem_rd), 1);
    idle(2);
    chk("R11 increment still applied", int'(bus_addr), 'h2ABD);

    // R3: load during rendering stays off the bus
    @(negedge clk); dot = 9'd2;
    set_addr(8'h12, 8'h34);
    idle(1);
    chk("R3 load hidden from bus while rendering", int'(bus_addr), 'h2ABD);
    render_en = 1'b0;
    cpu_r();
    chk("R6 read uses bus, not video address", int'(mem_addr), 'h2ABD);
    idle(2);
    chk("R3 increment reaches bus outside rendering", int'(bus_addr), 'h1235);

    idle(3);
    finish_run();
  end
endmodule